// File: doc/BRIEF.md
# Up/Down Binary/Decade Counter

A single 4-bit counting stage that steps up or down on the rising clock edge. A mode input chooses, while the counter runs, between a full binary cycle of sixteen states and a decade cycle of ten states (0 to 9). Counting happens only while an active-low enable is asserted. A parallel load strobe is asynchronous and overrides the clock. While the strobe is high, the output shows the data word with no delay.

An active-low terminal-count flag is decoded from the visible count, the direction, the mode and the enable. The flag is combinational. This lets several stages share one clock and form multi-digit counters: the flag of the lower stage feeds the enable of the next stage. In decade mode, an out-of-range code (10 to 15) recovers to a legal digit on the next count step and never raises the flag.

Top module: `updown_decade_counter`

## Requirements
- R1: While `load` is 1, `count` equals `din` at once, with no clock edge needed, and `load` takes priority over counting and holding.
- R2: On a rising `clk` edge where `load` is 0 and `cnt_en_n` is 0, the count moves by exactly one step in the selected direction (`count_up` = 1 up, 0 down).
- R3: On a rising `clk` edge where `load` is 0 and `cnt_en_n` is 1, the count keeps its value.
- R4: With `bin_mode` = 1 the modulus is 16: an up step from 15 gives 0, and a down step from 0 gives 15.
- R5: With `bin_mode` = 0 the modulus is 10: an up step from 9 gives 0, and a down step from 0 gives 9.
- R6: `tc_n` is 1 whenever `cnt_en_n` is 1.
- R7: With `cnt_en_n` = 0 and `count_up` = 1, `tc_n` is 0 exactly when the count is 15 (`bin_mode` = 1) or 9 (`bin_mode` = 0).
- R8: With `cnt_en_n` = 0 and `count_up` = 0, `tc_n` is 0 exactly when the count is 0.
- R9: `tc_n` follows changes of `cnt_en_n`, `count_up` and `bin_mode` within the same cycle, with no clock edge.
- R10: With `bin_mode` = 0 and the count at 10 to 15, an up step gives 0, a down step gives 9, and `tc_n` stays 1.
- R11: After `load` falls, the count keeps the value it last took from `din` during the load, and the next enabled clock edge counts on from that value.
- R12: While `rst_n` is 0 and `load` is 0, the count is 0, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Count clock, rising edge active |
| rst_n | input | 1 | Asynchronous clear, active low |
| cnt_en_n | input | 1 | Count enable, active low |
| count_up | input | 1 | Direction: 1 up, 0 down |
| bin_mode | input | 1 | Modulus: 1 binary (16), 0 decade (10) |
| load | input | 1 | Asynchronous parallel load, active high |
| din | input | 4 | Parallel data word |
| count | output | 4 | Current count |
| tc_n | output | 1 | Terminal count, active low |

## Verification
On every clock the assertions check these rules: the output tracks the data during a load, the count holds when disabled, the binary up-step arithmetic, that the count stays within range in decade mode after a step, and that the flag is inactive while the enable is off or the code is illegal. Some behaviour falls between clock edges or needs a chain of states, and only the bench scenarios show it. This covers an asynchronous load raised in the middle of a cycle, a clear in the middle of a cycle, the flag reacting to mode and direction changes without a clock, and the carry and borrow through a two-digit cascade in both directions.

// File: rtl/udc_pkg.sv
package udc_pkg;
  localparam int DIGIT_W = 4;
  localparam int DEC_TOP = 9;
  localparam int BIN_TOP = (1 << DIGIT_W) - 1;

  typedef logic [DIGIT_W-1:0] digit_t;

  // largest legal value of the selected modulus
  function automatic digit_t top_value(input logic bin);
    return bin ? digit_t'(BIN_TOP) : digit_t'(DEC_TOP);
  endfunction

  // one count step; illegal decade codes recover to 0 (up) or DEC_TOP (down)
  function automatic digit_t step_value(input digit_t q, input logic up, input logic bin);
    if (bin) begin
      return up ? q + digit_t'(1) : q - digit_t'(1);
    end
    if (up) begin
      return (q >= digit_t'(DEC_TOP)) ? '0 : q + digit_t'(1);
    end
    return ((q == '0) || (q > digit_t'(DEC_TOP))) ? digit_t'(DEC_TOP) : q - digit_t'(1);
  endfunction

  // count sits on the edge of its range in the chosen direction
  function automatic logic at_limit(input digit_t q, input logic up, input logic bin);
    return up ? (q == top_value(bin)) : (q == '0);
  endfunction
endpackage

// File: rtl/udc_next.sv
module udc_next
  import udc_pkg::*;
(
  input  digit_t cur,
  input  logic   count_up,
  input  logic   bin_mode,
  output digit_t nxt
);
  always_comb begin
    nxt = step_value(cur, count_up, bin_mode);
  end
endmodule

// File: rtl/udc_tc.sv
module udc_tc
  import udc_pkg::*;
(
  input  digit_t shown,
  input  logic   cnt_en_n,
  input  logic   count_up,
  input  logic   bin_mode,
  output logic   limit_hit,
  output logic   tc_n
);
  always_comb begin
    limit_hit = at_limit(shown, count_up, bin_mode);
    tc_n      = ~(limit_hit & ~cnt_en_n);
  end
endmodule

// File: rtl/udc_state.sv
module udc_state
  import udc_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   load,
  input  digit_t din,
  input  logic   advance,
  input  digit_t nxt,
  output digit_t q
);
  always_ff @(posedge clk or posedge load or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (load) begin
      q <= din;
    end else if (advance) begin
      q <= nxt;
    end
  end
endmodule

// File: rtl/updown_decade_counter.sv
module updown_decade_counter
  import udc_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cnt_en_n,
  input  logic               count_up,
  input  logic               bin_mode,
  input  logic               load,
  input  logic [DIGIT_W-1:0] din,
  output logic [DIGIT_W-1:0] count,
  output logic               tc_n
);
  digit_t state_q;
  digit_t step_nxt;
  logic   step_fire;
  logic   limit_hit;

  assign step_fire = ~load & ~cnt_en_n;

  udc_next u_next (
    .cur      (state_q),
    .count_up (count_up),
    .bin_mode (bin_mode),
    .nxt      (step_nxt)
  );

  udc_state u_state (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load),
    .din     (din),
    .advance (step_fire),
    .nxt     (step_nxt),
    .q       (state_q)
  );

  // load is transparent to the output so the data shows before any edge
  assign count = load ? din : state_q;

  udc_tc u_tc (
    .shown     (count),
    .cnt_en_n  (cnt_en_n),
    .count_up  (count_up),
    .bin_mode  (bin_mode),
    .limit_hit (limit_hit),
    .tc_n      (tc_n)
  );
endmodule

// File: rtl/udc_checker.sv
module udc_checker
  import udc_pkg::*;
(
  input logic   clk,
  input logic   rst_n,
  input logic   cnt_en_n,
  input logic   count_up,
  input logic   bin_mode,
  input logic   load,
  input digit_t din,
  input digit_t count,
  input logic   tc_n,
  input logic   step_fire
);
  p_load_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (count == din));

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && $past(!load) && $past(cnt_en_n)) |-> (count == $past(count)));

  p_bin_up_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && $past(step_fire && bin_mode && count_up)) |-> (count == digit_t'($past(count) + digit_t'(1))));

  p_dec_in_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && $past(step_fire && !bin_mode)) |-> (count <= digit_t'(DEC_TOP)));

  p_tc_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_en_n |-> tc_n);

  p_tc_illegal_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!bin_mode && (count > digit_t'(DEC_TOP))) |-> tc_n);
endmodule

bind updown_decade_counter udc_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cnt_en_n  (cnt_en_n),
  .count_up  (count_up),
  .bin_mode  (bin_mode),
  .load      (load),
  .din       (din),
  .count     (count),
  .tc_n      (tc_n),
  .step_fire (step_fire)
);

// File: tb/updown_decade_counter_test.sv
`timescale 1ns/1ps
module updown_decade_counter_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cnt_en_n = 1'b1;
  logic       count_up = 1'b1;
  logic       bin_mode = 1'b1;
  logic       load = 1'b0;
  logic [3:0] din = 4'd0;
  logic [3:0] count;
  logic       tc_n;
  logic       hi_load = 1'b0;
  logic [3:0] hi_count;
  logic       hi_tc_n;

  int total = 0;
  int fails = 0;

  always #4 clk = ~clk;

  updown_decade_counter uut (
    .clk(clk), .rst_n(rst_n), .cnt_en_n(cnt_en_n), .count_up(count_up),
    .bin_mode(bin_mode), .load(load), .din(din), .count(count), .tc_n(tc_n)
  );

  // upper digit of a two-stage cascade, enabled by the lower stage flag
  updown_decade_counter hi_stage (
    .clk(clk), .rst_n(rst_n), .cnt_en_n(tc_n), .count_up(count_up),
    .bin_mode(bin_mode), .load(hi_load), .din(4'd0), .count(hi_count), .tc_n(hi_tc_n)
  );

  // fields: load, din, en_n, up, bin, expected count, expected tc_n
  localparam int NV = 17;
  localparam logic [12:0] VEC [NV] = '{
    {1'b1, 4'd7,  1'b1, 1'b1, 1'b1, 4'd7,  1'b1},
    {1'b0, 4'd0,  1'b0, 1'b1, 1'b1, 4'd8,  1'b1},
    {1'b0, 4'd0,  1'b1, 1'b1, 1'b1, 4'd8,  1'b1},
    {1'b1, 4'd14, 1'b0, 1'b1, 1'b1, 4'd14, 1'b1},
    {1'b0, 4'd0,  1'b0, 1'b1, 1'b1, 4'd15, 1'b0},
    {1'b0, 4'd0,  1'b0, 1'b1, 1'b1, 4'd0,  1'b1},
    {1'b0, 4'd0,  1'b0, 1'b0, 1'b1, 4'd15, 1'b1},
    {1'b1, 4'd1,  1'b0, 1'b0, 1'b1, 4'd1,  1'b1},
    {1'b0, 4'd0,  1'b0, 1'b0, 1'b1, 4'd0,  1'b0},
    {1'b0, 4'd0,  1'b0, 1'b0, 1'b0, 4'd9,  1'b1},
    {1'b0, 4'd0,  1'b0, 1'b1, 1'b0, 4'd0,  1'b1},
    {1'b0, 4'd0,  1'b0, 1'b1, 1'b0, 4'd1,  1'b1},
    {1'b1, 4'd12, 1'b0, 1'b1, 1'b0, 4'd12, 1'b1},
    {1'b0, 4'd0,  1'b0, 1'b1, 1'b0, 4'd0,  1'b1},
    {1'b1, 4'd13, 1'b0, 1'b0, 1'b0, 4'd13, 1'b1},
    {1'b0, 4'd0,  1'b0, 1'b0, 1'b0, 4'd9,  1'b1},
    {1'b0, 4'd0,  1'b1, 1'b1, 1'b0, 4'd9,  1'b1}
  };

  function automatic string vec_req(input int i);
    case (i)
      0, 3, 7: return "R1";
      1:       return "R2";
      2, 16:   return "R3";
      4:       return "R7";
      5, 6:    return "R4";
      8:       return "R8";
      9, 10, 11: return "R5";
      default: return "R10";
    endcase
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    total++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    chk("R12 reset count", int'(count), 0);
    chk("R6 reset tc_n", int'(tc_n), 1);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {load, din, cnt_en_n, count_up, bin_mode} = VEC[i][12:5];
      @(posedge clk);
      #2;
      chk({vec_req(i), " count"}, int'(count), int'(VEC[i][4:1]));
      chk({vec_req(i), " tc_n"}, int'(tc_n), int'(VEC[i][0]));
    end

    // R9: flag reacts between edges (count is 9, decade)
    @(negedge clk);
    count_up = 1'b1; bin_mode = 1'b0; cnt_en_n = 1'b0;
    #1 chk("R9 tc_n dec up at 9", int'(tc_n), 0);
    bin_mode = 1'b1;
    #1 chk("R9 tc_n bin up at 9", int'(tc_n), 1);
    bin_mode = 1'b0; count_up = 1'b0;
    #1 chk("R9 tc_n dec down at 9", int'(tc_n), 1);
    cnt_en_n = 1'b1; count_up = 1'b1;
    #0.5 chk("R6 tc_n disabled", int'(tc_n), 1);

    // R1 / R11: load raised mid-cycle, data changed while held
    @(negedge clk);
    #1 load = 1'b1; din = 4'd5; bin_mode = 1'b1;
    #1 chk("R1 async load value", int'(count), 5);
    din = 4'd3;
    #1 chk("R1 follows din", int'(count), 3);
    @(posedge clk);
    @(negedge clk);
    #1 load = 1'b0;
    #1 chk("R11 held after release", int'(count), 3);
    cnt_en_n = 1'b0; count_up = 1'b1;
    @(posedge clk);
    #2 chk("R11 counts on from load", int'(count), 4);

    // R12: clear mid-cycle
    @(negedge clk);
    cnt_en_n = 1'b1;
    #1 rst_n = 1'b0;
    #1 chk("R12 async clear", int'(count), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // cascade of two decade digits
    @(negedge clk);
    bin_mode = 1'b0; count_up = 1'b1; cnt_en_n = 1'b0;
    repeat (25) @(posedge clk);
    #2;
    chk("R7 cascade low digit up", int'(count), 5);
    chk("R7 cascade high digit up", int'(hi_count), 2);
    @(negedge clk);
    count_up = 1'b0;
    repeat (25) @(posedge clk);
    #2;
    chk("R8 cascade low digit down", int'(count), 0);
    chk("R8 cascade high digit down", int'(hi_count), 0);
    @(posedge clk);
    #2;
    chk("R5 cascade low wrap", int'(count), 9);
    chk("R5 cascade high wrap", int'(hi_count), 9);
    @(negedge clk);
    cnt_en_n = 1'b1;
    #1;

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule